// File: doc/BRIEF.md
# Instruction control decoder

This block turns the opcode and function fields of a 32-bit instruction word into the control vector for a single-cycle datapath. It is purely combinational. It has no clock, no reset and no state. The instruction's bits 31:26 go to the opcode input and bits 5:0 go to the function input. The outputs settle in the same cycle and drive the datapath's multiplexers, write enables and ALU operation.

Seven operations are recognised:

- register add and register subtract, both under the all-zero opcode and told apart by the function field;
- OR with an immediate;
- word load and word store;
- branch on equal;
- absolute jump.

The decoder has two levels. A match plane raises one line for each recognised instruction. A sum plane then ORs those lines into each control output. Any encoding that matches none of the seven drives every control output low, so that instruction has no architectural effect.

Top module: `insn_ctrl_dec`

## Requirements
- R1: op_i=000000 with fn_i=100000 (add) gives dst_rd_o=1, reg_we_o=1, imm_b_o=0, load_wb_o=0, mem_we_o=0, branch_o=0, jump_o=0, sext_o=0, alu_op_o=00.
- R2: op_i=000000 with fn_i=100010 (subtract) gives the same outputs as R1 except alu_op_o=01.
- R3: op_i=001101 (OR immediate) gives reg_we_o=1, imm_b_o=1, sext_o=0 (zero extension), dst_rd_o=0, alu_op_o=10, and all other outputs 0.
- R4: op_i=100011 (load) gives reg_we_o=1, imm_b_o=1, sext_o=1, load_wb_o=1, dst_rd_o=0, alu_op_o=00, and all other outputs 0.
- R5: op_i=101011 (store) gives mem_we_o=1, imm_b_o=1, sext_o=1, alu_op_o=00, and all other outputs 0.
- R6: op_i=000100 (branch on equal) gives branch_o=1, alu_op_o=01, and all other outputs 0.
- R7: op_i=000010 (jump) gives jump_o=1 and all other outputs 0.
- R8: Any other opcode, and opcode 000000 with any function value other than 100000 or 100010, drives every output to 0. This includes reg_we_o, mem_we_o, branch_o and jump_o.
- R9: For every opcode other than 000000, fn_i has no effect on any output.
- R10: At most one of reg_we_o, mem_we_o, branch_o and jump_o is 1 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Opcode field, instruction bits 31:26 |
| fn_i | input | 6 | Function field, instruction bits 5:0 |
| dst_rd_o | output | 1 | 1 selects the rd field as write register; 0 selects rt |
| imm_b_o | output | 1 | 1 feeds the extended immediate to the ALU's second operand |
| load_wb_o | output | 1 | 1 writes memory read data back instead of the ALU result |
| reg_we_o | output | 1 | Register file write enable |
| mem_we_o | output | 1 | Data memory write enable |
| branch_o | output | 1 | Conditional branch select for the next-PC logic |
| jump_o | output | 1 | Jump select for the next-PC logic |
| sext_o | output | 1 | 1 sign-extends the immediate; 0 zero-extends it |
| alu_op_o | output | 2 | 00 add, 01 subtract, 10 OR |

## Verification
Both fields are examined in the same cycle. The opcode match and the function match can therefore both see a familiar pattern at once, for example an I-type opcode arriving with fn_i holding the add or subtract code.

The bench provokes this by pairing every supported opcode with random function values, including the two arithmetic codes. It also sweeps all 64 opcodes with the add function value. Each case is judged by comparing the full control vector with a model in which only the opcode selects the row, except under the all-zero opcode.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int N_INSN = 7;

  localparam int K_ADD   = 0;
  localparam int K_SUB   = 1;
  localparam int K_ORI   = 2;
  localparam int K_LOAD  = 3;
  localparam int K_STORE = 4;
  localparam int K_BEQ   = 5;
  localparam int K_JUMP  = 6;

  localparam logic [OP_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;

  localparam logic [1:0] ALU_ADD = 2'b00;
  localparam logic [1:0] ALU_SUB = 2'b01;
  localparam logic [1:0] ALU_OR  = 2'b10;

  typedef struct packed {
    logic       dst_rd;
    logic       imm_b;
    logic       load_wb;
    logic       reg_we;
    logic       mem_we;
    logic       branch;
    logic       jump;
    logic       sext;
    logic [1:0] alu;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [OP_W-1:0] insn_opc(int k);
    case (k)
      K_ORI:   return OPC_ORI;
      K_LOAD:  return OPC_LOAD;
      K_STORE: return OPC_STORE;
      K_BEQ:   return OPC_BEQ;
      K_JUMP:  return OPC_JUMP;
      default: return OPC_REG;
    endcase
  endfunction

  function automatic logic insn_uses_fn(int k);
    return (k == K_ADD) || (k == K_SUB);
  endfunction

  function automatic logic [FN_W-1:0] insn_fn(int k);
    return (k == K_SUB) ? FN_SUB : FN_ADD;
  endfunction

  // one product-term row of the control table
  function automatic ctrl_t insn_row(int k);
    ctrl_t r;
    r = '0;
    case (k)
      K_ADD:   begin r.dst_rd = 1'b1; r.reg_we = 1'b1; r.alu = ALU_ADD; end
      K_SUB:   begin r.dst_rd = 1'b1; r.reg_we = 1'b1; r.alu = ALU_SUB; end
      K_ORI:   begin r.imm_b = 1'b1; r.reg_we = 1'b1; r.alu = ALU_OR; end
      K_LOAD:  begin r.imm_b = 1'b1; r.reg_we = 1'b1; r.load_wb = 1'b1;
                     r.sext = 1'b1; r.alu = ALU_ADD; end
      K_STORE: begin r.imm_b = 1'b1; r.mem_we = 1'b1; r.sext = 1'b1;
                     r.alu = ALU_ADD; end
      K_BEQ:   begin r.branch = 1'b1; r.alu = ALU_SUB; end
      K_JUMP:  begin r.jump = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/insn_match_plane.sv
module insn_match_plane
  import insn_dec_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [FN_W-1:0]   fn_i,
  output logic [N_INSN-1:0] hit_o
);

  for (genvar k = 0; k < N_INSN; k++) begin : g_term
    if (insn_uses_fn(k)) begin : g_with_fn
      assign hit_o[k] = (op_i == insn_opc(k)) && (fn_i == insn_fn(k));
    end else begin : g_op_only
      assign hit_o[k] = (op_i == insn_opc(k));
    end
  end

  // R9: one encoding never selects two rows
  always_comb begin
    p_single_hit_r9: assert ($onehot0(hit_o))
      else $error("match plane raised several rows");
  end

endmodule

// File: rtl/insn_sum_plane.sv
module insn_sum_plane
  import insn_dec_pkg::*;
(
  input  logic [N_INSN-1:0] hit_i,
  output ctrl_t             ctrl_o
);

  function automatic logic [N_INSN-1:0] col_mask(int j);
    logic [N_INSN-1:0] m;
    logic [CTRL_W-1:0] row;
    for (int k = 0; k < N_INSN; k++) begin
      row  = insn_row(k);
      m[k] = row[j];
    end
    return m;
  endfunction

  logic [CTRL_W-1:0] ctrl_bits;

  for (genvar j = 0; j < CTRL_W; j++) begin : g_col
    assign ctrl_bits[j] = |(hit_i & col_mask(j));
  end

  assign ctrl_o = ctrl_t'(ctrl_bits);

  // R8: no recognised row, no control activity
  always_comb begin
    if (hit_i == '0) begin
      p_idle_r8: assert (ctrl_o == '0)
        else $error("control active without a matched row");
    end
  end

endmodule

// File: rtl/insn_ctrl_dec.sv
module insn_ctrl_dec
  import insn_dec_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output logic       dst_rd_o,
  output logic       imm_b_o,
  output logic       load_wb_o,
  output logic       reg_we_o,
  output logic       mem_we_o,
  output logic       branch_o,
  output logic       jump_o,
  output logic       sext_o,
  output logic [1:0] alu_op_o
);

  logic [N_INSN-1:0] hit;
  ctrl_t             ctrl;

  insn_match_plane u_match (
    .op_i  (op_i),
    .fn_i  (fn_i),
    .hit_o (hit)
  );

  insn_sum_plane u_sum (
    .hit_i  (hit),
    .ctrl_o (ctrl)
  );

  assign dst_rd_o  = ctrl.dst_rd;
  assign imm_b_o   = ctrl.imm_b;
  assign load_wb_o = ctrl.load_wb;
  assign reg_we_o  = ctrl.reg_we;
  assign mem_we_o  = ctrl.mem_we;
  assign branch_o  = ctrl.branch;
  assign jump_o    = ctrl.jump;
  assign sext_o    = ctrl.sext;
  assign alu_op_o  = ctrl.alu;

  always_comb begin
    p_excl_we_r10: assert ($onehot0({reg_we_o, mem_we_o, branch_o, jump_o}))
      else $error("two state-changing controls at once");
    if (branch_o) begin
      p_branch_sub_r6: assert (alu_op_o == ALU_SUB && !reg_we_o)
        else $error("branch without compare");
    end
    if (mem_we_o) begin
      p_store_addr_r5: assert (imm_b_o && sext_o && alu_op_o == ALU_ADD)
        else $error("store address path wrong");
    end
    if (load_wb_o) begin
      p_load_wb_r4: assert (reg_we_o && imm_b_o && sext_o)
        else $error("load writeback without register write");
    end
  end

endmodule

// File: tb/insn_ctrl_dec_bench.sv
module insn_ctrl_dec_bench;

  logic       clk = 1'b0;
  logic [5:0] op, fn;
  logic       dst_rd, imm_b, load_wb, reg_we, mem_we, branch, jump, sext;
  logic [1:0] alu;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  insn_ctrl_dec u_insn_ctrl_dec (
    .op_i      (op),
    .fn_i      (fn),
    .dst_rd_o  (dst_rd),
    .imm_b_o   (imm_b),
    .load_wb_o (load_wb),
    .reg_we_o  (reg_we),
    .mem_we_o  (mem_we),
    .branch_o  (branch),
    .jump_o    (jump),
    .sext_o    (sext),
    .alu_op_o  (alu)
  );

  // {dst_rd, imm_b, load_wb, reg_we, mem_we, branch, jump, sext, alu[1:0]}
  function automatic logic [9:0] model(logic [5:0] o, logic [5:0] f);
    case (o)
      6'b000000: begin
        if (f == 6'b100000) return 10'b1001000000;
        if (f == 6'b100010) return 10'b1001000001;
        return 10'b0;
      end
      6'b001101: return 10'b0101000010;
      6'b100011: return 10'b0111000100;
      6'b101011: return 10'b0100100100;
      6'b000100: return 10'b0000010001;
      6'b000010: return 10'b0000001000;
      default:   return 10'b0;
    endcase
  endfunction

  function automatic string req_of(logic [5:0] o, logic [5:0] f);
    case (o)
      6'b000000: return (f == 6'b100000) ? "R1" : (f == 6'b100010) ? "R2" : "R8";
      6'b001101: return "R3";
      6'b100011: return "R4";
      6'b101011: return "R5";
      6'b000100: return "R6";
      6'b000010: return "R7";
      default:   return "R8";
    endcase
  endfunction

  task automatic apply(logic [5:0] o, logic [5:0] f);
    logic [9:0] got, exp;
    @(negedge clk);
    op = o;
    fn = f;
    #1;
    got = {dst_rd, imm_b, load_wb, reg_we, mem_we, branch, jump, sext, alu};
    exp = model(o, f);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b",
               req_of(o, f), o, f, got, exp);
    end
    // R10: exclusive state-changing controls
    n_checks++;
    if ($countones({reg_we, mem_we, branch, jump}) > 1) begin
      n_errors++;
      $display("FAIL R10 op=%b fn=%b actual=%b expected=onehot0",
               o, f, {reg_we, mem_we, branch, jump});
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0] ops [6];
    ops[0] = 6'b000000; ops[1] = 6'b001101; ops[2] = 6'b100011;
    ops[3] = 6'b101011; ops[4] = 6'b000100; ops[5] = 6'b000010;
    void'($urandom(32'd4242));
    op = '0;
    fn = '0;
    // idle state: op 0, fn 0 is unrecognised (R8)
    apply(6'b000000, 6'b000000);
    apply(6'b000000, 6'b100000); // R1
    apply(6'b000000, 6'b100010); // R2
    apply(6'b001101, 6'b000000); // R3
    apply(6'b100011, 6'b111111); // R4
    apply(6'b101011, 6'b010101); // R5
    apply(6'b000100, 6'b100010); // R6
    apply(6'b000010, 6'b100000); // R7
    apply(6'b000000, 6'b100001); // R8 near-miss funct
    apply(6'b000000, 6'b100100); // R8 other R-type funct
    apply(6'b111111, 6'b100000); // R8 unknown opcode
    // R9: every opcode, each with both arithmetic funct codes
    for (int o = 0; o < 64; o++) begin
      apply(6'(o), 6'b100000);
      apply(6'(o), 6'b100010);
    end
    // random funct over supported opcodes, then fully random words
    for (int i = 0; i < 1500; i++) begin
      apply(ops[$urandom_range(5)], 6'($urandom));
    end
    for (int i = 0; i < 1500; i++) begin
      apply(6'($urandom), 6'($urandom));
    end
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule